// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Bank

This block holds the digital state behind a four-channel converter. Each channel has a staging register, a live code register that drives the converter, and a gain trim word and an offset trim word. A frame decoder upstream delivers each finished frame as one write strobe with a register kind, a channel and a 16-bit value. Code writes always land in the staging registers. Whether they reach the converter depends on the active-low load pin `ld_n`. A falling edge on it copies all four staging registers into the live registers on one clock edge. While it stays low, each code write also goes straight through to its channel.

`ld_n` is brought into the clock domain by a synchronizer. A small transfer controller then follows it through three named states. `ST_HOLD` is the state with the load line high: writes are buffered only. Seeing the line low moves it to `ST_BCAST`. `ST_BCAST` lasts one cycle and performs the simultaneous copy. From there the controller goes to `ST_LIVE` if the line is still low, or back to `ST_HOLD` if it is high. `ST_LIVE` passes writes through, and returns to `ST_HOLD` when the line rises. The active-low clear pin `clr_n` acts asynchronously on the live registers only. It drives them to the 0 V code of the coding selected by `twos_sel`. A read port returns any staging or trim register without a clock.

Top module: `qdac_regbank`

## Requirements
- R1: While `rst_n` is low, and after it rises, the registers hold these values: every staging and live register holds the clear code of R6, every gain register holds 0xFFFF and every offset register holds 0x0000.
- R2: With `ld_n` high, a write of kind 0 (code) changes only the addressed channel's staging register. `dac_code` does not change.
- R3: A falling edge on `ld_n` copies all four staging registers into the live registers on one clock edge. That edge is the fourth rising clock edge after the fall. Channel c drives `dac_code[16c+15:16c]`.
- R4: While `ld_n` is held low, a code write also loads the addressed channel's live register on the edge that captures the write.
- R5: `clr_n` low forces every live register to the clear code at once, without waiting for a clock edge, and holds them there while it stays low.
- R6: The clear code is 0x0000 when `twos_sel` is 1 (twos complement). It is 0x8000 when `twos_sel` is 0 (offset binary).
- R7: Clear leaves the staging, gain and offset registers unchanged. After `clr_n` rises the live registers keep the clear code until the next load falling edge, which restores the staged values.
- R8: Reads return the register picked by `rd_kind` (0 code staging, 1 offset, 2 gain) and `rd_chan` in the same cycle. Kind 3 reads as 0x0000, and a write of kind 3 changes no register.
- R9: Writes of kind 1 or 2 never change `dac_code`, whatever the level of `ld_n`.
- R10: While `clr_n` is low, load edges and code writes leave `dac_code` at the clear code. Code writes still reach the staging registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of the live registers |
| ld_n | input | 1 | Active-low load line, asynchronous to clk |
| twos_sel | input | 1 | 1 selects twos complement coding, 0 selects offset binary |
| wr_en | input | 1 | One-cycle strobe marking the end of a write frame |
| wr_kind | input | 2 | Register kind of the write (0 code, 1 offset, 2 gain, 3 none) |
| wr_chan | input | 2 | Channel of the write |
| wr_data | input | 16 | Value written |
| rd_kind | input | 2 | Register kind to read back |
| rd_chan | input | 2 | Channel to read back |
| rd_data | output | 16 | Readback value |
| dac_code | output | 64 | Live codes, channel c in bits 16c+15..16c |

## Verification
The hardest case to reach from the ports is a channel whose staged code differs from its live code after a clear. The bench gets there by writing codes, broadcasting them, and then asserting `clr_n` between clock edges, so that a sample taken before the next edge shows the clear acted asynchronously. It then flips the coding pin and writes a new code while the clear is held. A load pulse during the clear must be blocked. Only a load after the release may bring the staged values, including the one written during the clear, back onto `dac_code`.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Register kind encoding shared by the write and read ports
    localparam logic [1:0] KIND_CODE   = 2'd0;
    localparam logic [1:0] KIND_OFFSET = 2'd1;
    localparam logic [1:0] KIND_GAIN   = 2'd2;
    localparam logic [1:0] KIND_NONE   = 2'd3;

    // Transfer controller states
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_BCAST = 2'd1,
        ST_LIVE  = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/qdac_ld_sync.sv
module qdac_ld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] sh_q;

    // Idle level of the load line is high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = sh_q[STAGES-1];

endmodule

// File: rtl/qdac_xfer_fsm.sv
module qdac_xfer_fsm
    import qdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_low,
    output xfer_state_t st_q,
    output logic        copy_all,
    output logic        live_mode
);

    xfer_state_t st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  if (ld_low) st_d = ST_BCAST;
            ST_BCAST: st_d = ld_low ? ST_LIVE : ST_HOLD;
            ST_LIVE:  if (!ld_low) st_d = ST_HOLD;
            default:  st_d = ST_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        copy_all  = 1'b0;
        live_mode = 1'b0;
        unique case (st_q)
            ST_HOLD:  ;
            ST_BCAST: begin
                copy_all  = 1'b1;
                live_mode = 1'b1;
            end
            ST_LIVE:  live_mode = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dat_arst_n,
    input  logic [W-1:0] clear_code,
    input  logic         wr_code,
    input  logic         wr_gain,
    input  logic         wr_off,
    input  logic [W-1:0] wr_data,
    input  logic         copy_all,
    input  logic         live_wr,
    output logic [W-1:0] stage_q,
    output logic [W-1:0] gain_q,
    output logic [W-1:0] off_q,
    output logic [W-1:0] live_q
);

    // Staging register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= clear_code;
        end else if (wr_code) begin
            stage_q <= wr_data;
        end
    end

    // Trim registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= '1;
            off_q  <= '0;
        end else begin
            if (wr_gain) gain_q <= wr_data;
            if (wr_off)  off_q  <= wr_data;
        end
    end

    // Live register: cleared by reset or clear, a direct write wins over the broadcast copy
    always_ff @(posedge clk or negedge dat_arst_n) begin
        if (!dat_arst_n) begin
            live_q <= clear_code;
        end else if (live_wr) begin
            live_q <= wr_data;
        end else if (copy_all) begin
            live_q <= stage_q;
        end
    end

endmodule

// File: rtl/qdac_readmux.sv
module qdac_readmux
    import qdac_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int W   = 16,
    localparam int CW  = $clog2(NCH)
) (
    input  logic [NCH*W-1:0] stage_flat,
    input  logic [NCH*W-1:0] gain_flat,
    input  logic [NCH*W-1:0] off_flat,
    input  logic [1:0]       rd_kind,
    input  logic [CW-1:0]    rd_chan,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] stage_sel, gain_sel, off_sel;

    always_comb begin
        stage_sel = '0;
        gain_sel  = '0;
        off_sel   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_chan == CW'(c)) begin
                stage_sel = stage_flat[c*W +: W];
                gain_sel  = gain_flat[c*W +: W];
                off_sel   = off_flat[c*W +: W];
            end
        end
    end

    always_comb begin
        unique case (rd_kind)
            KIND_CODE:   rd_data = stage_sel;
            KIND_OFFSET: rd_data = off_sel;
            KIND_GAIN:   rd_data = gain_sel;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter  int NCH         = 4,
    parameter  int W           = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int CW          = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             twos_sel,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [CW-1:0]    wr_chan,
    input  logic [W-1:0]     wr_data,
    input  logic [1:0]       rd_kind,
    input  logic [CW-1:0]    rd_chan,
    output logic [W-1:0]     rd_data,
    output logic [NCH*W-1:0] dac_code
);

    logic             ld_sync;
    logic             copy_all;
    logic             live_mode;
    xfer_state_t      st_q;
    logic [W-1:0]     clear_code;
    logic             dat_arst_n;
    logic [NCH*W-1:0] stage_flat;
    logic [NCH*W-1:0] gain_flat;
    logic [NCH*W-1:0] off_flat;

    // 0 V code: mid-scale in offset binary, zero in twos complement
    assign clear_code = twos_sel ? '0 : {1'b1, {(W-1){1'b0}}};
    assign dat_arst_n = rst_n & clr_n;

    qdac_ld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ld_n),
        .sync_out (ld_sync)
    );

    qdac_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_low    (~ld_sync),
        .st_q      (st_q),
        .copy_all  (copy_all),
        .live_mode (live_mode)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_chan == CW'(c));

        qdac_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .dat_arst_n (dat_arst_n),
            .clear_code (clear_code),
            .wr_code    (hit && (wr_kind == KIND_CODE)),
            .wr_gain    (hit && (wr_kind == KIND_GAIN)),
            .wr_off     (hit && (wr_kind == KIND_OFFSET)),
            .wr_data    (wr_data),
            .copy_all   (copy_all),
            .live_wr    (live_mode && hit && (wr_kind == KIND_CODE)),
            .stage_q    (stage_flat[c*W +: W]),
            .gain_q     (gain_flat[c*W +: W]),
            .off_q      (off_flat[c*W +: W]),
            .live_q     (dac_code[c*W +: W])
        );
    end

    qdac_readmux #(.NCH(NCH), .W(W)) u_rd (
        .stage_flat (stage_flat),
        .gain_flat  (gain_flat),
        .off_flat   (off_flat),
        .rd_kind    (rd_kind),
        .rd_chan    (rd_chan),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/qdac_regbank_chk.sv
module qdac_regbank_chk
    import qdac_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int W   = 16,
    localparam int CW  = $clog2(NCH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             twos_sel,
    input logic             wr_en,
    input logic [1:0]       wr_kind,
    input logic [CW-1:0]    wr_chan,
    input logic [W-1:0]     wr_data,
    input logic [1:0]       rd_kind,
    input logic [W-1:0]     rd_data,
    input logic [NCH*W-1:0] dac_code,
    input logic [NCH*W-1:0] stage_flat,
    input xfer_state_t      st_q
);

    function automatic logic [W-1:0] lane(input logic [NCH*W-1:0] v, input logic [CW-1:0] i);
        return v[i*W +: W];
    endfunction

    logic [W-1:0] zero_volt;
    assign zero_volt = twos_sel ? '0 : {1'b1, {(W-1){1'b0}}};

    // R5 / R6: clear holds every live code at the 0 V code of the selected coding
    a_r5_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && $stable(twos_sel)) |-> (dac_code == {NCH{zero_volt}}));

    // R2 / R9: no live register moves while the controller buffers only
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && clr_n) |=> (!clr_n || $stable(dac_code)));

    // R3: the broadcast state copies every staging register together
    a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BCAST && !wr_en && clr_n) |=> (!clr_n || dac_code == $past(stage_flat)));

    // R3: the controller never enters pass-through without a broadcast first
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> (st_q != ST_LIVE));

    // R4: in pass-through a code write reaches its live register on the capturing edge
    a_r4_live_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LIVE && wr_en && wr_kind == KIND_CODE && clr_n)
        |=> (!clr_n || lane(dac_code, $past(wr_chan)) == $past(wr_data)));

    // R8: the unused kind reads as zero
    a_r8_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == KIND_NONE) |-> (rd_data == '0));

endmodule

bind qdac_regbank qdac_regbank_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .twos_sel   (twos_sel),
    .wr_en      (wr_en),
    .wr_kind    (wr_kind),
    .wr_chan    (wr_chan),
    .wr_data    (wr_data),
    .rd_kind    (rd_kind),
    .rd_data    (rd_data),
    .dac_code   (dac_code),
    .stage_flat (stage_flat),
    .st_q       (st_q)
);

// File: tb/tb_qdac_regbank.sv
module tb_qdac_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        ld_n = 1'b1;
    logic        twos_sel = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic [1:0]  wr_chan = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_kind = 2'd0;
    logic [1:0]  rd_chan = 2'd0;
    logic [15:0] rd_data;
    logic [63:0] dac_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    qdac_regbank dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .twos_sel (twos_sel),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_chan  (wr_chan),
        .wr_data  (wr_data),
        .rd_kind  (rd_kind),
        .rd_chan  (rd_chan),
        .rd_data  (rd_data),
        .dac_code (dac_code)
    );

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_LD  = 3'd1;
    localparam logic [2:0] OP_RD  = 3'd2;
    localparam logic [2:0] OP_DAC = 3'd3;

    // {req[42:39], op[38:36], kind[35:34], chan[33:32], data[31:16], expect[15:0]}
    localparam int NV = 24;
    localparam logic [42:0] VEC [NV] = '{
        {4'd2, OP_WR,  2'd0, 2'd0, 16'h1111, 16'h0000},  // R2
        {4'd2, OP_WR,  2'd0, 2'd1, 16'h2222, 16'h0000},  // R2
        {4'd2, OP_WR,  2'd0, 2'd2, 16'h3333, 16'h0000},  // R2
        {4'd2, OP_WR,  2'd0, 2'd3, 16'h4444, 16'h0000},  // R2
        {4'd2, OP_DAC, 2'd0, 2'd0, 16'h0000, 16'h0000},  // R2
        {4'd2, OP_DAC, 2'd0, 2'd3, 16'h0000, 16'h0000},  // R2
        {4'd8, OP_RD,  2'd0, 2'd2, 16'h0000, 16'h3333},  // R8
        {4'd8, OP_WR,  2'd2, 2'd1, 16'hABCD, 16'h0000},  // R8
        {4'd8, OP_WR,  2'd1, 2'd2, 16'h0123, 16'h0000},  // R8
        {4'd8, OP_RD,  2'd2, 2'd1, 16'h0000, 16'hABCD},  // R8
        {4'd8, OP_RD,  2'd1, 2'd2, 16'h0000, 16'h0123},  // R8
        {4'd1, OP_RD,  2'd2, 2'd0, 16'h0000, 16'hFFFF},  // R1
        {4'd1, OP_RD,  2'd1, 2'd3, 16'h0000, 16'h0000},  // R1
        {4'd8, OP_WR,  2'd3, 2'd0, 16'hDEAD, 16'h0000},  // R8
        {4'd8, OP_RD,  2'd3, 2'd0, 16'h0000, 16'h0000},  // R8
        {4'd8, OP_RD,  2'd0, 2'd0, 16'h0000, 16'h1111},  // R8
        {4'd9, OP_DAC, 2'd0, 2'd1, 16'h0000, 16'h0000},  // R9
        {4'd3, OP_LD,  2'd0, 2'd0, 16'h0000, 16'h0000},  // R3
        {4'd3, OP_DAC, 2'd0, 2'd0, 16'h0000, 16'h1111},  // R3
        {4'd3, OP_DAC, 2'd0, 2'd1, 16'h0000, 16'h2222},  // R3
        {4'd3, OP_DAC, 2'd0, 2'd2, 16'h0000, 16'h3333},  // R3
        {4'd3, OP_DAC, 2'd0, 2'd3, 16'h0000, 16'h4444},  // R3
        {4'd2, OP_WR,  2'd0, 2'd0, 16'h5555, 16'h0000},  // R2
        {4'd2, OP_DAC, 2'd0, 2'd0, 16'h0000, 16'h1111}   // R2
    };

    function automatic logic [15:0] lane(input int c);
        return dac_code[c*16 +: 16];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] k, input logic [1:0] c, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_chan = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [1:0] k, input logic [1:0] c, input logic [15:0] exp);
        rd_kind = k; rd_chan = c;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic pulse_ld();
        @(negedge clk);
        ld_n = 1'b0;
        repeat (6) @(negedge clk);
        ld_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, twos complement
        repeat (3) @(negedge clk);
        for (int c = 0; c < 4; c++) check("R1 live code in reset", lane(c), 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read("R1 staging after reset", 2'd0, 2'd3, 16'h0000);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vector %0d", v[42:39], i);
            case (v[38:36])
                OP_WR:  do_write(v[35:34], v[33:32], v[31:16]);
                OP_LD:  pulse_ld();
                OP_RD:  do_read(tag, v[35:34], v[33:32], v[15:0]);
                default: check(tag, lane(int'(v[33:32])), v[15:0]);
            endcase
        end

        // R4: pass-through while the load line is held low
        @(negedge clk);
        ld_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 staged 5555 copied at fall", lane(0), 16'h5555);
        do_write(2'd0, 2'd1, 16'h7777);
        check("R4 live write ch1", lane(1), 16'h7777);
        do_write(2'd2, 2'd2, 16'h0F0F);
        check("R9 gain write with load low", lane(2), 16'h3333);
        do_read("R8 gain ch2", 2'd2, 2'd2, 16'h0F0F);
        ld_n = 1'b1;
        repeat (6) @(negedge clk);

        // R5: clear acts between edges
        @(negedge clk);
        #2 clr_n = 1'b0;
        #1;
        for (int c = 0; c < 4; c++) check("R5 async clear before edge", lane(c), 16'h0000);
        @(negedge clk);
        twos_sel = 1'b0;
        @(negedge clk);
        check("R6 offset binary clear code", lane(0), 16'h8000);
        do_write(2'd0, 2'd3, 16'h9999);
        check("R10 write during clear", lane(3), 16'h8000);
        pulse_ld();
        check("R10 load during clear ch3", lane(3), 16'h8000);
        check("R10 load during clear ch1", lane(1), 16'h8000);
        @(negedge clk);
        clr_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 clear code held after release", lane(0), 16'h8000);
        do_read("R7 staging kept", 2'd0, 2'd3, 16'h9999);
        do_read("R7 gain kept", 2'd2, 2'd2, 16'h0F0F);
        do_read("R7 offset kept", 2'd1, 2'd2, 16'h0123);
        pulse_ld();
        check("R7 restore ch0", lane(0), 16'h5555);
        check("R7 restore ch1", lane(1), 16'h7777);
        check("R7 restore ch2", lane(2), 16'h3333);
        check("R7 restore ch3", lane(3), 16'h9999);

        // R1 / R6: reset under offset binary coding
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 live reset offset binary", lane(2), 16'h8000);
        do_read("R1 staging reset offset binary", 2'd0, 2'd1, 16'h8000);
        do_read("R1 gain reset", 2'd2, 2'd3, 16'hFFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule